// File: doc/BRIEF.md
# Disc subcode symbol serial port

This block takes the per-frame subcode symbols of a disc stream (eight bits, one from each of the P, Q, R, S, T, U, V and W channels) and hands each one to a host over a one-bit serial line. The host clocks the line itself. Symbols come in on a valid/ready stream and wait in a one-entry slot. The slot is emptied only when the frame strobe ends.

A frame tick (for example from a 7.35 kHz divider of the crystal clock) raises the frame strobe for a fixed number of system cycles. The falling edge of the strobe moves the waiting symbol into the shifter, and the P bit appears on the serial output at once. Each rising edge of the host clock advances the output by one channel, in P-to-W order. The host clock is brought into the system clock domain by a synchroniser and an edge detector first. The host is expected to finish its eight reads well before the next strobe falls; a fixed window of roughly 136 µs at the nominal frame rate.

A block-sync flag follows the 98-frame subcode block. It is high while the symbol on display belongs to one of the two sync frames. Its falling edge marks the first data symbol of the block.

Back-pressure rules for the input stream: a symbol is taken on a cycle where `sym_valid` and `sym_ready` are both high. `sym_ready` is high exactly while the slot is empty. After a transfer it stays low until the next strobe fall empties the slot.

Top module: `subq_symbol_port`

## Requirements
- R1: After reset, `ser_data`, `sym_strobe` and `blk_sync` are low and `sym_ready` is high.
- R2: A symbol is taken on a cycle with `sym_valid` and `sym_ready` both high. `sym_ready` is then low on the next cycle and stays low until the strobe falling edge consumes the slot. At that point it returns high unless a new symbol is taken in that same cycle.
- R3: A `frame_tick` pulse while the strobe is low raises `sym_strobe` on the next clock edge for exactly STROBE_CYC cycles. A tick that arrives while the strobe is high is ignored.
- R4: On the clock edge where `sym_strobe` falls, the waiting symbol is loaded. `ser_data` then shows its bit 7, which is the P bit. Bit 7 is P and bit 0 is W.
- R5: Each rising edge of `host_clk` moves `ser_data` to the next lower bit (Q = bit 6, down to W = bit 0). The change is visible within SYNC_STAGES+1 system clock cycles of the host edge.
- R6: While `host_clk` does not rise, `ser_data` holds its bit, which is P after a load.
- R7: After the seventh host rising edge, `ser_data` shows W (bit 0). Any further host edges leave it at W until the next load.
- R8: Taking a new symbol from the stream while a read is in progress does not change `ser_data`.
- R9: If the slot is empty when the strobe falls, the shifter loads 0x00 and that frame is counted as a data frame.
- R10: A loaded symbol with `sym_first` high is frame 0 of a block. Each later load increments the frame index, which wraps from FRAMES_PER_BLK-1 back to 0. `blk_sync` is high exactly while the loaded frame index is below SYNC_FRAMES (0 and 1 by default), and it changes only on load edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle pulse per subcode frame |
| sym_valid | input | 1 | Stream: symbol offered |
| sym_ready | output | 1 | Stream: slot empty, symbol will be taken |
| sym_bits | input | SYM_W | Symbol, bit 7 = P down to bit 0 = W |
| sym_first | input | 1 | Symbol is frame 0 of a subcode block |
| host_clk | input | 1 | Host shift clock, asynchronous |
| sym_strobe | output | 1 | Frame strobe; falling edge = new symbol ready |
| blk_sync | output | 1 | High while a block sync frame is on display |
| ser_data | output | 1 | Serial subcode bit |

## Verification
The bench builds the block with STROBE_CYC = 4 and FRAMES_PER_BLK = 6, with SYNC_FRAMES and SYNC_STAGES at their defaults. The short block brings the index wrap and the return of `blk_sync` into reach within a few frames. The short strobe keeps the cycle count of each frame small. With the 2-stage synchroniser, the bench can hold each host clock level for four system cycles and still see every step of the shifter.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  localparam int SYM_BITS = 8;

  typedef struct packed {
    logic                first;
    logic [SYM_BITS-1:0] bits;
  } sbq_sym_t;
endpackage

// File: rtl/sbq_host_sync.sv
module sbq_host_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/sbq_frame_seq.sv
module sbq_frame_seq #(
  parameter int STROBE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  output logic strobe,
  output logic load
);
  localparam int CW = $clog2(STROBE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    else if (frame_tick)     cnt_q <= CW'(STROBE_CYC);
  end

  assign strobe = (cnt_q != '0);
  assign load   = (cnt_q == CW'(1));
endmodule

// File: rtl/sbq_shifter.sv
module sbq_shifter
  import sbq_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_bits,
  input  logic             in_first,
  input  logic             load,
  input  logic             adv,
  output logic             load_first,
  output logic             ser
);
  localparam int PW = (SYM_W > 1) ? $clog2(SYM_W) : 1;

  logic [SYM_W-1:0] pend_bits_q;
  logic             pend_first_q;
  logic             pend_full_q;
  logic [SYM_W-1:0] sh_q;
  logic [PW-1:0]    pos_q;
  logic             take;

  assign in_ready   = ~pend_full_q;
  assign take       = in_valid & in_ready;
  assign load_first = pend_full_q & pend_first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_bits_q  <= '0;
      pend_first_q <= 1'b0;
      pend_full_q  <= 1'b0;
    end else begin
      if (take) begin
        pend_bits_q  <= in_bits;
        pend_first_q <= in_first;
        pend_full_q  <= 1'b1;
      end else if (load) begin
        pend_full_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      pos_q <= '0;
    end else if (load) begin
      sh_q  <= pend_full_q ? pend_bits_q : '0;
      pos_q <= '0;
    end else if (adv && (pos_q != PW'(SYM_W - 1))) begin
      sh_q  <= {sh_q[SYM_W-2:0], 1'b0};
      pos_q <= pos_q + 1'b1;
    end
  end

  assign ser = sh_q[SYM_W-1];
endmodule

// File: rtl/sbq_block_track.sv
module sbq_block_track #(
  parameter int FRAMES_PER_BLK = 98,
  parameter int SYNC_FRAMES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic first,
  output logic blk_sync
);
  localparam int IW = $clog2(FRAMES_PER_BLK);

  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_n;

  always_comb begin
    if (first)                               idx_n = '0;
    else if (idx_q == IW'(FRAMES_PER_BLK-1)) idx_n = '0;
    else                                     idx_n = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= IW'(FRAMES_PER_BLK-1);
      blk_sync <= 1'b0;
    end else if (load) begin
      idx_q    <= idx_n;
      blk_sync <= (idx_n < IW'(SYNC_FRAMES));
    end
  end
endmodule

// File: rtl/subq_symbol_port.sv
module subq_symbol_port #(
  parameter int SYM_W          = 8,
  parameter int STROBE_CYC     = 8,
  parameter int FRAMES_PER_BLK = 98,
  parameter int SYNC_FRAMES    = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_bits,
  input  logic             sym_first,
  input  logic             host_clk,
  output logic             sym_strobe,
  output logic             blk_sync,
  output logic             ser_data
);
  logic load;
  logic adv;
  logic load_first;

  sbq_host_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(host_clk), .rise(adv)
  );

  sbq_frame_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .strobe(sym_strobe), .load(load)
  );

  sbq_shifter #(.SYM_W(SYM_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sym_valid), .in_ready(sym_ready),
    .in_bits(sym_bits), .in_first(sym_first),
    .load(load), .adv(adv),
    .load_first(load_first), .ser(ser_data)
  );

  sbq_block_track #(
    .FRAMES_PER_BLK(FRAMES_PER_BLK), .SYNC_FRAMES(SYNC_FRAMES)
  ) u_blk (
    .clk(clk), .rst_n(rst_n), .load(load), .first(load_first),
    .blk_sync(blk_sync)
  );
endmodule

// File: rtl/sbq_checker.sv
module sbq_checker #(
  parameter int STROBE_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic sym_valid,
  input logic sym_ready,
  input logic sym_strobe,
  input logic blk_sync,
  input logic ser_data,
  input logic load,
  input logic adv
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_cnt <= '0;
    else if (sym_strobe) hi_cnt <= hi_cnt + 1;
    else                 hi_cnt <= '0;
  end

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> !sym_ready);

  p_ready_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_ready && !load) |=> !sym_ready);

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sym_strobe) |-> (hi_cnt == STROBE_CYC));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(ser_data));

  p_flag_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(blk_sync));

  p_load_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> $fell(sym_strobe));
endmodule

bind subq_symbol_port sbq_checker #(.STROBE_CYC(STROBE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
  .sym_strobe(sym_strobe), .blk_sync(blk_sync), .ser_data(ser_data),
  .load(load), .adv(adv)
);

// File: tb/sim_subq_symbol_port.sv
`timescale 1ns/1ps
module sim_subq_symbol_port;
  localparam int SW  = 8;
  localparam int STB = 4;
  localparam int FPB = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic sym_valid = 1'b0;
  logic sym_ready;
  logic [SW-1:0] sym_bits = '0;
  logic sym_first = 1'b0;
  logic host_clk = 1'b0;
  logic sym_strobe, blk_sync, ser_data;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  subq_symbol_port #(
    .SYM_W(SW), .STROBE_CYC(STB), .FRAMES_PER_BLK(FPB),
    .SYNC_FRAMES(2), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_bits(sym_bits),
    .sym_first(sym_first), .host_clk(host_clk), .sym_strobe(sym_strobe),
    .blk_sync(blk_sync), .ser_data(ser_data)
  );

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [SW-1:0] b, input logic f);
    while (!sym_ready) @(negedge clk);
    sym_bits = b; sym_first = f; sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic frame();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    cyc(STB + 2);
  endtask

  task automatic hpulse();
    host_clk = 1'b1; cyc(4);
    host_clk = 1'b0; cyc(4);
  endtask

  task automatic t_reset();
    check(ser_data == 1'b0,   "R1 ser_data",   int'(ser_data),   0);
    check(sym_strobe == 1'b0, "R1 sym_strobe", int'(sym_strobe), 0);
    check(blk_sync == 1'b0,   "R1 blk_sync",   int'(blk_sync),   0);
    check(sym_ready == 1'b1,  "R1 sym_ready",  int'(sym_ready),  1);
  endtask

  task automatic t_strobe();
    int hi;
    hi = 0;
    frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
    if (sym_strobe) hi++;
    frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
    if (sym_strobe) hi++;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sym_strobe) hi++;
    end
    check(hi == STB, "R3 strobe width, extra tick ignored", hi, STB);
  endtask

  task automatic t_serial();
    logic [SW-1:0] v;
    v = 8'hA5;
    push(v, 1'b1);
    check(sym_ready == 1'b0, "R2 ready low after take", int'(sym_ready), 0);
    frame();
    check(sym_ready == 1'b1, "R2 ready back after load", int'(sym_ready), 1);
    check(ser_data == v[7], "R4 P bit after strobe fall", int'(ser_data), int'(v[7]));
    check(blk_sync == 1'b1, "R10 first frame is sync", int'(blk_sync), 1);
    for (int k = 1; k <= 10; k++) begin
      int b;
      hpulse();
      b = (k > 7) ? 0 : 7 - k;
      if (k <= 7) check(ser_data == v[b], "R5 bit order P..W", int'(ser_data), int'(v[b]));
      else        check(ser_data == v[0], "R7 hold W after 8th", int'(ser_data), int'(v[0]));
    end
  endtask

  task automatic t_noclk();
    push(8'hC3, 1'b0);
    frame();
    check(ser_data == 1'b1, "R4 P bit shown", int'(ser_data), 1);
    cyc(30);
    check(ser_data == 1'b1, "R6 no host clock keeps P", int'(ser_data), 1);
  endtask

  task automatic t_midread();
    logic [SW-1:0] v;
    v = 8'h96;
    push(v, 1'b0);
    frame();
    repeat (3) hpulse();
    check(ser_data == v[4], "R5 fourth bit", int'(ser_data), int'(v[4]));
    push(8'h0F, 1'b0);
    cyc(3);
    check(ser_data == v[4], "R8 new symbol leaves read alone", int'(ser_data), int'(v[4]));
    check(sym_ready == 1'b0, "R2 back-pressure while slot full", int'(sym_ready), 0);
    hpulse();
    check(ser_data == v[3], "R8 read continues", int'(ser_data), int'(v[3]));
    frame();
    check(ser_data == 1'b0, "R4 next symbol P bit", int'(ser_data), 0);
    hpulse(); hpulse(); hpulse(); hpulse();
    check(ser_data == 1'b1, "R5 next symbol T bit", int'(ser_data), 1);
  endtask

  task automatic t_underrun();
    int ones;
    frame();
    ones = int'(ser_data);
    for (int k = 0; k < 8; k++) begin
      hpulse();
      ones += int'(ser_data);
    end
    check(ones == 0, "R9 empty slot loads zero", ones, 0);
  endtask

  task automatic t_block();
    push(8'h80, 1'b1);
    for (int f = 0; f < FPB + 2; f++) begin
      int idx;
      int exp;
      if (f > 0) push(8'h80, 1'b0);
      frame();
      idx = f % FPB;
      exp = (idx < 2) ? 1 : 0;
      check(int'(blk_sync) == exp, "R10 sync flag vs frame index", int'(blk_sync), exp);
    end
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_strobe();
    t_serial();
    t_noclk();
    t_midread();
    t_underrun();
    t_block();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule